// File: doc/BRIEF.md
# TDM Network-Mode Slot Controller

This block steps through the time slots of each frame on a synchronous serial audio link that runs in network (time-division multiplexed) mode. It counts bit-clock ticks within a slot and slots within a frame. For every slot it uses two independent active-slot masks, one for transmit and one for receive. From them it decides whether the slot loads and shifts out a transmit word, whether the data line is driven or released, and whether a received word is captured. When one slot is programmed, the port acts as a plain continuous serial link and the masks play no part.

The controller also checks the configuration. It reports network mode, encodes the slot width into a size field with an extended-size flag, and refuses to run when network mode has no transmit slot. Towards the sample buffers it gives only a request strobe after each burst of words, plus a flag for the request width.

Top module: `tdm_slot_ctrl`

## Requirements
- R1: `net_mode` is 1 exactly when the slot count is greater than 1. A count of 0 is treated as 1 and counts above 8 as 8. For a width w of 16 or less, `ext_size`=0 and `size_field`=w. For w from 17 to 32, `ext_size`=1 and `size_field`=w-16.
- R2: `cfg_err` is 1 when `net_mode`=1 and `tx_mask`=0. `running` follows `run_req && !cfg_err` one clock later, so a port with a configuration error never starts.
- R3: The configuration is held steady while the port runs. A bit-clock tick with `frame_start`=1 puts the position at slot 0, bit 0. Each later tick advances the bit, and after w bits the next slot begins. Positions at or past the slot count, and all positions before the first frame start, are out of frame (`slot_valid`=0) until the next frame start. `cur_slot` gives the slot index while `slot_valid`=1.
- R4: Bit i of `tx_mask` marks slot i as transmit-active. After the tick that enters bit 0 of a transmit-active slot, `tx_load` pulses for one clock and `tx_word` is taken. `tx_sd` then presents the word's bit w-1 first, down to bit 0 at the slot's last bit (MSB first).
- R5: While running, `tx_oe` is 1 in transmit-active slots. In every other position it equals `!tri_en`.
- R6: Bit i of `rx_mask` marks slot i as receive-active, and `rx_sd` is sampled on each tick of such a slot. After the tick of the slot's last bit, `rx_cap` pulses for one clock and `rx_word` holds the w bits received in the slot, the first bit received as the MSB, zero-extended.
- R7: When the slot count is 1, both masks are ignored. Slot 0 repeats with no further frame starts, every word is loaded and captured, and `cfg_err` stays 0 even with an empty transmit mask.
- R8: `req_wide` = (`stereo` and `tx_mask` does not have exactly one bit set) or `samp32`.
- R9: `tx_req` is high together with every 16th `tx_load` of a run, and `rx_req` together with every 16th `rx_cap`.
- R10: While `running`=0, `tx_oe`, `slot_valid`, `tx_load` and `rx_cap` are 0, and the next run starts from out-of-frame with cleared request counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Request to run the port |
| bclk_en | input | 1 | One-clock tick per serial bit |
| frame_start | input | 1 | Frame start, taken together with a tick |
| cfg_slots | input | 4 | Slots per frame (1..8) |
| cfg_width | input | 6 | Bits per slot (1..32) |
| tx_mask | input | 8 | Transmit-active slots, bit i for slot i |
| rx_mask | input | 8 | Receive-active slots, bit i for slot i |
| tri_en | input | 1 | Release the line in inactive positions |
| stereo | input | 1 | Two-channel traffic |
| samp32 | input | 1 | 32-bit samples |
| tx_word | input | 32 | Word to send, right-aligned |
| rx_sd | input | 1 | Serial receive data |
| running | output | 1 | Port is running |
| net_mode | output | 1 | Network mode active |
| cfg_err | output | 1 | Network mode without transmit slot |
| ext_size | output | 1 | Extended-size flag |
| size_field | output | 5 | Encoded slot width |
| slot_valid | output | 1 | Current position is inside the frame |
| cur_slot | output | 3 | Current slot index |
| tx_load | output | 1 | Transmit word taken |
| tx_oe | output | 1 | Drive enable for the data line |
| tx_sd | output | 1 | Serial transmit data |
| rx_cap | output | 1 | Received word ready |
| rx_word | output | 32 | Received word, right-aligned |
| req_wide | output | 1 | Requests are 32 bits wide |
| tx_req | output | 1 | Transmit burst request |
| rx_req | output | 1 | Receive burst request |

## Verification
The slot sequencer is swept over slot counts of 1, 2, 3, 4 and 8 and widths of 8, 16, 20 and 32. Sparse, dense and complementary transmit and receive masks separate per-slot gating from frame-length gating. The mask bits above the slot count in one case show that positions past the frame stay inactive. A frame start in mid-slot checks that the position is realigned. A single-slot run with empty masks tells continuous mode apart from network mode and reaches the 16th word for the burst requests. The width and slot encodings and the request-width flag are checked over all widths and mask patterns, and tristate on and off separate released from driven idle positions.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int SIZE_SPLIT = 16;

  function automatic int clamp_range(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic bit size_is_ext(input int w);
    return w > SIZE_SPLIT;
  endfunction

  function automatic int size_code(input int w);
    return (w > SIZE_SPLIT) ? (w - SIZE_SPLIT) : w;
  endfunction
endpackage

// File: rtl/tdm_slot_pos.sv
module tdm_slot_pos #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W = 32,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int SIDX_W = $clog2(MAX_SLOTS),
  localparam int BIT_W = $clog2(MAX_W),
  localparam int WCFG_W = $clog2(MAX_W + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              tick,
  input  logic              frame_start,
  input  logic              net_mode,
  input  logic [CNT_W-1:0]  slots_eff,
  input  logic [WCFG_W-1:0] width_eff,
  output logic [SIDX_W-1:0] slot_q,
  output logic              in_q,
  output logic [SIDX_W-1:0] nxt_slot,
  output logic              nxt_in,
  output logic              nxt_first,
  output logic              nxt_last
);
  logic [BIT_W-1:0] bit_q, nxt_bit;
  logic [CNT_W-1:0] slot_inc;
  logic             last_bit;

  assign slot_inc = CNT_W'(slot_q) + CNT_W'(1);
  assign last_bit = (WCFG_W'(bit_q) + WCFG_W'(1)) == width_eff;

  always_comb begin
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    nxt_in   = in_q;
    if (frame_start) begin
      nxt_slot = '0;
      nxt_bit  = '0;
      nxt_in   = 1'b1;
    end else if (in_q) begin
      if (last_bit) begin
        nxt_bit = '0;
        if (!net_mode) begin
          nxt_slot = '0;
        end else if (slot_inc < slots_eff) begin
          nxt_slot = slot_inc[SIDX_W-1:0];
        end else begin
          nxt_in = 1'b0;
        end
      end else begin
        nxt_bit = bit_q + BIT_W'(1);
      end
    end
  end

  assign nxt_first = (nxt_bit == '0);
  assign nxt_last  = (WCFG_W'(nxt_bit) + WCFG_W'(1)) == width_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
      in_q   <= 1'b0;
    end else if (!run_q) begin
      slot_q <= '0;
      bit_q  <= '0;
      in_q   <= 1'b0;
    end else if (tick) begin
      slot_q <= nxt_slot;
      bit_q  <= nxt_bit;
      in_q   <= nxt_in;
    end
  end
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift #(
  parameter int MAX_W = 32,
  localparam int WCFG_W = $clog2(MAX_W + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              act,
  input  logic              first,
  input  logic [WCFG_W-1:0] width_eff,
  input  logic [MAX_W-1:0]  word,
  output logic              tx_load,
  output logic              tx_sd
);
  logic [MAX_W-1:0] sh;
  logic             load_now;

  assign load_now = tick && act && first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= load_now;
      if (load_now) begin
        sh <= word << (MAX_W - int'(width_eff));
      end else if (tick) begin
        sh <= sh << 1;
      end
    end
  end

  assign tx_sd = sh[MAX_W-1];
endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift #(
  parameter int MAX_W = 32,
  localparam int WCFG_W = $clog2(MAX_W + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              act,
  input  logic              last,
  input  logic [WCFG_W-1:0] width_eff,
  input  logic              rx_sd,
  output logic              rx_cap,
  output logic [MAX_W-1:0]  rx_word
);
  logic [MAX_W-1:0] sh, sh_nxt, keep;

  assign sh_nxt = {sh[MAX_W-2:0], rx_sd};
  assign keep   = {MAX_W{1'b1}} >> (MAX_W - int'(width_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      rx_cap  <= 1'b0;
      rx_word <= '0;
    end else begin
      rx_cap <= tick && act && last;
      if (tick && act) begin
        sh <= sh_nxt;
        if (last) rx_word <= sh_nxt & keep;
      end
    end
  end
endmodule

// File: rtl/tdm_burst_req.sv
module tdm_burst_req #(
  parameter int BURST = 16,
  localparam int CW = (BURST > 1) ? $clog2(BURST) : 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic ev,
  output logic req
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(BURST - 1));
  assign req    = ev && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run_q) begin
      cnt <= '0;
    end else if (ev) begin
      cnt <= at_end ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W = 32,
  parameter int BURST = 16,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int SIDX_W = $clog2(MAX_SLOTS),
  localparam int WCFG_W = $clog2(MAX_W + 1),
  localparam int FIELD_W = $clog2(MAX_W / 2 + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic               bclk_en,
  input  logic               frame_start,
  input  logic [CNT_W-1:0]   cfg_slots,
  input  logic [WCFG_W-1:0]  cfg_width,
  input  logic [MAX_SLOTS-1:0] tx_mask,
  input  logic [MAX_SLOTS-1:0] rx_mask,
  input  logic               tri_en,
  input  logic               stereo,
  input  logic               samp32,
  input  logic [MAX_W-1:0]   tx_word,
  input  logic               rx_sd,
  output logic               running,
  output logic               net_mode,
  output logic               cfg_err,
  output logic               ext_size,
  output logic [FIELD_W-1:0] size_field,
  output logic               slot_valid,
  output logic [SIDX_W-1:0]  cur_slot,
  output logic               tx_load,
  output logic               tx_oe,
  output logic               tx_sd,
  output logic               rx_cap,
  output logic [MAX_W-1:0]   rx_word,
  output logic               req_wide,
  output logic               tx_req,
  output logic               rx_req
);
  import tdm_slot_pkg::*;

  logic [CNT_W-1:0]  slots_eff;
  logic [WCFG_W-1:0] width_eff;
  logic              tick;
  logic [SIDX_W-1:0] slot_q, nxt_slot;
  logic              in_q, nxt_in, nxt_first, nxt_last;
  logic              cur_tx_act, nxt_tx_act, nxt_rx_act;
  logic [1:0]        burst_ev, burst_req;

  // configuration decode
  assign slots_eff  = CNT_W'(clamp_range(int'(cfg_slots), 1, MAX_SLOTS));
  assign width_eff  = WCFG_W'(clamp_range(int'(cfg_width), 1, MAX_W));
  assign net_mode   = slots_eff > CNT_W'(1);
  assign cfg_err    = net_mode && (tx_mask == '0);
  assign ext_size   = size_is_ext(int'(width_eff));
  assign size_field = FIELD_W'(size_code(int'(width_eff)));
  assign req_wide   = (stereo && ($countones(tx_mask) != 1)) || samp32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run_req && !cfg_err;
  end

  assign tick = bclk_en && running;

  tdm_slot_pos #(.MAX_SLOTS(MAX_SLOTS), .MAX_W(MAX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .run_q(running), .tick(tick),
    .frame_start(frame_start), .net_mode(net_mode),
    .slots_eff(slots_eff), .width_eff(width_eff),
    .slot_q(slot_q), .in_q(in_q), .nxt_slot(nxt_slot), .nxt_in(nxt_in),
    .nxt_first(nxt_first), .nxt_last(nxt_last)
  );

  // slot activity from the masks; single-slot mode ignores them
  assign cur_tx_act = in_q   && (!net_mode || tx_mask[slot_q]);
  assign nxt_tx_act = nxt_in && (!net_mode || tx_mask[nxt_slot]);
  assign nxt_rx_act = nxt_in && (!net_mode || rx_mask[nxt_slot]);

  assign slot_valid = running && in_q;
  assign cur_slot   = slot_q;
  assign tx_oe      = running && (cur_tx_act || !tri_en);

  tdm_tx_shift #(.MAX_W(MAX_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(nxt_tx_act),
    .first(nxt_first), .width_eff(width_eff), .word(tx_word),
    .tx_load(tx_load), .tx_sd(tx_sd)
  );

  tdm_rx_shift #(.MAX_W(MAX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(nxt_rx_act),
    .last(nxt_last), .width_eff(width_eff), .rx_sd(rx_sd),
    .rx_cap(rx_cap), .rx_word(rx_word)
  );

  assign burst_ev = {rx_cap, tx_load};

  for (genvar d = 0; d < 2; d++) begin : g_req
    tdm_burst_req #(.BURST(BURST)) u_req (
      .clk(clk), .rst_n(rst_n), .run_q(running),
      .ev(burst_ev[d]), .req(burst_req[d])
    );
  end

  assign tx_req = burst_req[0];
  assign rx_req = burst_req[1];
endmodule

// File: rtl/tdm_slot_ctrl_chk.sv
module tdm_slot_ctrl_chk #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W = 32,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int SIDX_W = $clog2(MAX_SLOTS),
  localparam int FIELD_W = $clog2(MAX_W / 2 + 1)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               running,
  input logic               cfg_err,
  input logic               net_mode,
  input logic               ext_size,
  input logic [FIELD_W-1:0] size_field,
  input logic               slot_valid,
  input logic [SIDX_W-1:0]  cur_slot,
  input logic [CNT_W-1:0]   slots_eff,
  input logic               tx_load,
  input logic               tx_oe,
  input logic               rx_cap,
  input logic               tx_req,
  input logic               rx_req
);
  p_ext_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_size |-> (size_field >= FIELD_W'(1) && size_field <= FIELD_W'(16)));

  p_err_blocks_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !running);

  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> (CNT_W'(cur_slot) < slots_eff));

  p_load_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> tx_oe);

  p_cap_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap |-> slot_valid);

  p_single_slot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !net_mode) |-> (cur_slot == '0));

  p_tx_req_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_load);

  p_rx_req_on_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> rx_cap);

  p_idle_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!tx_load && !rx_cap));
endmodule

bind tdm_slot_ctrl tdm_slot_ctrl_chk #(.MAX_SLOTS(MAX_SLOTS), .MAX_W(MAX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .running(running), .cfg_err(cfg_err),
  .net_mode(net_mode), .ext_size(ext_size), .size_field(size_field),
  .slot_valid(slot_valid), .cur_slot(cur_slot), .slots_eff(slots_eff),
  .tx_load(tx_load), .tx_oe(tx_oe), .rx_cap(rx_cap),
  .tx_req(tx_req), .rx_req(rx_req)
);

// File: tb/tdm_slot_ctrl_tb_top.sv
module tdm_slot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_req = 1'b0, bclk_en = 1'b0, frame_start = 1'b0;
  logic [3:0]  cfg_slots = 4'd1;
  logic [5:0]  cfg_width = 6'd8;
  logic [7:0]  tx_mask = 8'h00, rx_mask = 8'h00;
  logic        tri_en = 1'b0, stereo = 1'b0, samp32 = 1'b0;
  logic [31:0] tx_word = '0;
  logic        rx_sd = 1'b0;
  logic        running, net_mode, cfg_err, ext_size, slot_valid;
  logic [4:0]  size_field;
  logic [2:0]  cur_slot;
  logic        tx_load, tx_oe, tx_sd, rx_cap, req_wide, tx_req, rx_req;
  logic [31:0] rx_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdm_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .bclk_en(bclk_en),
    .frame_start(frame_start), .cfg_slots(cfg_slots), .cfg_width(cfg_width),
    .tx_mask(tx_mask), .rx_mask(rx_mask), .tri_en(tri_en), .stereo(stereo),
    .samp32(samp32), .tx_word(tx_word), .rx_sd(rx_sd), .running(running),
    .net_mode(net_mode), .cfg_err(cfg_err), .ext_size(ext_size),
    .size_field(size_field), .slot_valid(slot_valid), .cur_slot(cur_slot),
    .tx_load(tx_load), .tx_oe(tx_oe), .tx_sd(tx_sd), .rx_cap(rx_cap),
    .rx_word(rx_word), .req_wide(req_wide), .tx_req(tx_req), .rx_req(rx_req)
  );

  task automatic chk_eq(input string req, input string what,
                        input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] txpat(input int s);
    return 32'hC6A4_A793 ^ (32'h0101_0101 * (s + 3)) ^ 32'h8000_0001;
  endfunction

  function automatic logic [31:0] rxpat(input int s);
    return 32'h5A3C_96E1 + 32'h1357_9BDF * s;
  endfunction

  function automatic longint wmask(input int w);
    return (longint'(1) << w) - 1;
  endfunction

  task automatic do_tick(input bit fs, input bit rxb, input logic [31:0] word);
    @(negedge clk);
    bclk_en = 1'b1; frame_start = fs; rx_sd = rxb; tx_word = word;
    @(negedge clk);
    bclk_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic run_cfg(input int slots, input int w, input logic [7:0] txm,
                         input logic [7:0] rxm, input bit tri_sel,
                         input int total, input int restart);
    int ld, cp, k, slot, b;
    bit single, inf, txa, rxa, eload, ecap, rxb;
    logic [31:0] pw;
    ld = 0; cp = 0; k = 0;
    @(negedge clk);
    cfg_slots = 4'(slots); cfg_width = 6'(w); tx_mask = txm; rx_mask = rxm;
    tri_en = tri_sel; run_req = 1'b1;
    @(negedge clk);
    chk_eq("R2", "running after start", running, 1);
    for (int p = 0; p < 2; p++) begin
      do_tick(1'b0, 1'b0, 32'h0);
      chk_eq("R3", "slot_valid before frame", slot_valid, 0);
      chk_eq("R5", "tx_oe before frame", tx_oe, !tri_sel);
      chk_eq("R4", "tx_load before frame", tx_load, 0);
    end
    single = (slots <= 1);
    for (int t = 0; t < total; t++) begin
      if (t == restart) k = 0;
      slot = single ? 0 : k / w;
      b = k % w;
      inf = single || (k < slots * w);
      txa = 1'b0; rxa = 1'b0;
      if (inf) begin
        txa = single || txm[slot];
        rxa = single || rxm[slot];
      end
      pw = rxpat(slot);
      rxb = inf ? pw[w-1-b] : 1'b0;
      do_tick(k == 0, rxb, txpat(slot));
      eload = txa && (b == 0);
      ecap  = rxa && (b == w - 1);
      chk_eq("R3", "slot_valid", slot_valid, inf);
      if (inf) chk_eq("R3", "cur_slot", cur_slot, slot);
      chk_eq("R4", "tx_load", tx_load, eload);
      chk_eq("R5", "tx_oe", tx_oe, txa || !tri_sel);
      if (txa) begin
        pw = txpat(slot);
        chk_eq(single ? "R7" : "R4", "tx_sd", tx_sd, pw[w-1-b]);
      end
      chk_eq(single ? "R7" : "R6", "rx_cap", rx_cap, ecap);
      if (ecap) chk_eq("R6", "rx_word", rx_word, longint'(rxpat(slot)) & wmask(w));
      chk_eq("R9", "tx_req", tx_req, eload && (ld % 16 == 15));
      chk_eq("R9", "rx_req", rx_req, ecap && (cp % 16 == 15));
      if (eload) ld++;
      if (ecap) cp++;
      k++;
    end
    @(negedge clk);
    run_req = 1'b0;
    @(negedge clk);
    chk_eq("R10", "running after stop", running, 0);
    chk_eq("R10", "tx_oe stopped", tx_oe, 0);
    chk_eq("R10", "slot_valid stopped", slot_valid, 0);
    do_tick(1'b1, 1'b0, 32'h0);
    chk_eq("R10", "tx_load stopped", tx_load, 0);
    chk_eq("R10", "rx_cap stopped", rx_cap, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10", "reset running", running, 0);
    chk_eq("R10", "reset tx_oe", tx_oe, 0);
    chk_eq("R10", "reset tx_load", tx_load, 0);
    chk_eq("R10", "reset slot_valid", slot_valid, 0);

    // R1: width and slot-count encodings
    for (int w = 1; w <= 32; w++) begin
      cfg_width = 6'(w);
      #1;
      chk_eq("R1", "ext_size", ext_size, w > 16);
      chk_eq("R1", "size_field", size_field, (w > 16) ? w - 16 : w);
    end
    tx_mask = 8'h01;
    for (int s = 0; s <= 8; s++) begin
      cfg_slots = 4'(s);
      #1;
      chk_eq("R1", "net_mode", net_mode, s > 1);
    end

    // R8: request width
    for (int st = 0; st < 2; st++) begin
      for (int s32 = 0; s32 < 2; s32++) begin
        for (int m = 0; m < 5; m++) begin
          logic [7:0] mv;
          int ones;
          mv = (m == 0) ? 8'h01 : (m == 1) ? 8'h03 : (m == 2) ? 8'h80 :
               (m == 3) ? 8'h00 : 8'hFF;
          ones = 0;
          for (int i = 0; i < 8; i++) ones += mv[i];
          stereo = st[0]; samp32 = s32[0]; tx_mask = mv;
          #1;
          chk_eq("R8", "req_wide", req_wide, (st == 1 && ones != 1) || s32 == 1);
        end
      end
    end
    stereo = 1'b0; samp32 = 1'b0;

    // R2: network mode with no transmit slot must not start
    @(negedge clk);
    cfg_slots = 4'd4; cfg_width = 6'd8; tx_mask = 8'h00; rx_mask = 8'hFF;
    #1;
    chk_eq("R2", "cfg_err empty mask", cfg_err, 1);
    run_req = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R2", "running with error", running, 0);
    do_tick(1'b1, 1'b1, 32'hFFFF_FFFF);
    chk_eq("R2", "no load with error", tx_load, 0);
    chk_eq("R2", "no capture with error", rx_cap, 0);
    run_req = 1'b0;
    cfg_slots = 4'd1;
    #1;
    chk_eq("R7", "cfg_err single slot empty mask", cfg_err, 0);
    @(negedge clk);

    // main sweep
    run_cfg(4, 8,  8'h05, 8'h0A, 1'b1, 4 * 8 + 6, -1);
    run_cfg(8, 16, 8'hC3, 8'h3C, 1'b0, 8 * 16 + 4, -1);
    run_cfg(3, 20, 8'h06, 8'hFF, 1'b1, 3 * 20 + 3, -1);
    run_cfg(2, 32, 8'h02, 8'h01, 1'b1, 2 * 32 + 2, -1);
    run_cfg(1, 8,  8'h00, 8'h00, 1'b1, 20 * 8, -1);
    run_cfg(4, 8,  8'h0F, 8'h0F, 1'b0, 13 + 32 + 2, 13);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule